// File: doc/BRIEF.md
# Joinable Dual Word FIFO with Sticky Debug Flags

This block holds the two word queues between a bus master and one sequencer. The TX queue carries words from the bus to the machine. The RX queue carries words from the machine back to the bus. The bus side has single-cycle write and read strobes. The machine side uses a valid/ready handshake in each direction.

Both queues share one storage array of twice the per-queue depth. A two-bit join control can give the whole array to TX or to RX, which doubles that queue and closes the other one. A change of the join control empties both queues. A flush pulse empties them too. The block drives full and empty status per direction and two level interrupt requests, each with its own enable. Four sticky flags record misuse of the queues: a machine waiting on an empty TX, a bus write into a full TX, a bus read from an empty RX, and a machine offering to a full RX. Writing a one to a flag's bit of the clear input clears that flag.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After reset both queues are empty (tx_empty=1, rx_empty=1, tx_full=0, rx_full=0), all four debug flags are 0, and the join mode is unjoined.
- R2: With join_mode=0 the TX queue holds DEPTH (4) words in first-in first-out order. tx_full rises after the fourth accepted write. A machine transfer happens in a cycle with mc_tx_ready=1 and mc_tx_valid=1, and mc_tx_data shows the oldest word in that cycle.
- R3: With join_mode=0 the RX queue holds 4 words in first-in first-out order. mc_rx_ready is the inverse of rx_full. bus_rd_data shows the oldest word during the cycle in which bus_rd_en is high.
- R4: join_mode=1 (join to TX) gives TX a depth of 8. RX then reports rx_full=1 and rx_empty=1 and accepts no machine word.
- R5: join_mode=2 (join to RX) gives RX a depth of 8. TX then reports tx_full=1 and tx_empty=1 and accepts no bus write. join_mode=3 acts as join_mode=0.
- R6: When the join mode changes, both queues are empty from the next cycle, and the new mode applies from that cycle.
- R7: A one-cycle flush pulse discards every queued word in both queues. The next word written is the next word read.
- R8: irq_tx = irq_tx_en AND NOT tx_full; irq_rx = irq_rx_en AND NOT rx_empty.
- R9: A bus write to a full TX is dropped and sets dbg_flags bit 1 (TX overflow). A bus read of an empty RX returns 0 and sets dbg_flags bit 2 (RX underflow).
- R10: mc_tx_ready=1 while TX is empty sets dbg_flags bit 0 (TX stall) at the first such cycle. mc_rx_valid=1 while RX is full sets dbg_flags bit 3 (RX stall).
- R11: A 1 in a bit of dbg_clr clears that flag at the next edge and leaves the other flags unchanged. If a flag's set condition and its clear bit occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| join_mode | input | 2 | 0 unjoined, 1 join to TX, 2 join to RX, 3 as 0 |
| flush | input | 1 | Discard all queued words |
| bus_wr_en | input | 1 | Bus write strobe into TX |
| bus_wr_data | input | 32 | Bus write word |
| bus_rd_en | input | 1 | Bus read strobe from RX |
| bus_rd_data | output | 32 | Oldest RX word, 0 when RX is empty |
| mc_tx_valid | output | 1 | TX holds a word for the machine |
| mc_tx_ready | input | 1 | Machine takes a TX word |
| mc_tx_data | output | 32 | Oldest TX word |
| mc_rx_valid | input | 1 | Machine offers an RX word |
| mc_rx_ready | output | 1 | RX can accept a word |
| mc_rx_data | input | 32 | Machine RX word |
| tx_full | output | 1 | TX full |
| tx_empty | output | 1 | TX empty |
| rx_full | output | 1 | RX full |
| rx_empty | output | 1 | RX empty |
| irq_tx_en | input | 1 | Enable for irq_tx |
| irq_rx_en | input | 1 | Enable for irq_rx |
| irq_tx | output | 1 | TX not full, gated by its enable |
| irq_rx | output | 1 | RX not empty, gated by its enable |
| dbg_clr | input | 4 | Write-one-to-clear mask for dbg_flags |
| dbg_flags | output | 4 | Bit 0 TX stall, 1 TX overflow, 2 RX underflow, 3 RX stall |

## Verification
The bench fills each queue to its exact depth, both unjoined and joined, and checks that full rises on the last word and not one word earlier. An off-by-one capacity or a missed base offset would show as early or late full, or as RX words overwriting TX words. It writes past full and reads past empty. A design that lets the dropped word through, or returns stale data instead of zero, fails the order and data checks. It also tests a mode change with words still queued, a flush followed by a fresh word, and a clear that arrives in the same cycle as a new stall. A design that keeps stale words, misaligns its pointers after the flush, or lets the clear win over the set would report it there.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
    typedef enum logic [1:0] {
        JOIN_NONE = 2'd0,
        JOIN_TX   = 2'd1,
        JOIN_RX   = 2'd2
    } join_e;

    localparam int NUM_FLAGS   = 4;
    localparam int FLG_TXSTALL = 0;
    localparam int FLG_TXOVER  = 1;
    localparam int FLG_RXUNDER = 2;
    localparam int FLG_RXSTALL = 3;
endpackage

// File: rtl/xfer_fifo_mem.sv
module xfer_fifo_mem #(
    parameter int DW    = 32,
    parameter int SLOTS = 8,
    localparam int AW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] mem_q [SLOTS];

    always_ff @(posedge clk) begin
        if (wa_en) mem_q[wa_addr] <= wa_data;
        if (wb_en) mem_q[wb_addr] <= wb_data;
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];

    // R4
    disjoint_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en) |-> (wa_addr != wb_addr));
endmodule

// File: rtl/xfer_fifo_ptr.sv
module xfer_fifo_ptr #(
    parameter int SLOTS = 8,
    localparam int AW   = $clog2(SLOTS),
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic          pop,
    output logic          push_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic    pop_fire;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] idx, input logic [CW-1:0] lim);
        if (CW'(idx) + CW'(1) >= lim) return '0;
        return idx + AW'(1);
    endfunction

    assign full      = (st_q.cnt == cap);
    assign empty     = (st_q.cnt == '0);
    assign push_fire = push && !full && !flush;
    assign pop_fire  = pop && !empty && !flush;
    assign wr_addr   = base + st_q.wr;
    assign rd_addr   = base + st_q.rd;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_fire) st_d.wr = step(st_q.wr, cap);
            if (pop_fire)  st_d.rd = step(st_q.rd, cap);
            case ({push_fire, pop_fire})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= cap);
endmodule

// File: rtl/xfer_fifo_dbg.sv
module xfer_fifo_dbg #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);
    typedef struct packed {
        logic [NF-1:0] flags;
    } dbg_st_t;

    dbg_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
    import xfer_fifo_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    join_mode,
    input  logic          flush,
    input  logic          bus_wr_en,
    input  logic [DW-1:0] bus_wr_data,
    input  logic          bus_rd_en,
    output logic [DW-1:0] bus_rd_data,
    output logic          mc_tx_valid,
    input  logic          mc_tx_ready,
    output logic [DW-1:0] mc_tx_data,
    input  logic          mc_rx_valid,
    output logic          mc_rx_ready,
    input  logic [DW-1:0] mc_rx_data,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          rx_empty,
    input  logic          irq_tx_en,
    input  logic          irq_rx_en,
    output logic          irq_tx,
    output logic          irq_rx,
    input  logic [NUM_FLAGS-1:0] dbg_clr,
    output logic [NUM_FLAGS-1:0] dbg_flags
);
    localparam int SLOTS = 2 * DEPTH;
    localparam int AW    = $clog2(SLOTS);
    localparam int CW    = $clog2(SLOTS + 1);

    typedef struct packed {
        join_e mode;
    } top_st_t;

    top_st_t st_d, st_q;
    join_e   mode_req;
    logic    flush_all;
    logic [CW-1:0] tx_cap, rx_cap;
    logic [AW-1:0] rx_base;
    logic [AW-1:0] tx_wa, tx_ra, rx_wa, rx_ra;
    logic          tx_push, rx_push;
    logic [DW-1:0] tx_head, rx_head;
    logic [NUM_FLAGS-1:0] flag_set;

    always_comb begin
        case (join_mode)
            2'd1:    mode_req = JOIN_TX;
            2'd2:    mode_req = JOIN_RX;
            default: mode_req = JOIN_NONE;
        endcase
        st_d      = st_q;
        st_d.mode = mode_req;
        flush_all = flush || (mode_req != st_q.mode);
        case (st_q.mode)
            JOIN_TX: begin tx_cap = CW'(SLOTS); rx_cap = '0;         rx_base = '0;         end
            JOIN_RX: begin tx_cap = '0;         rx_cap = CW'(SLOTS); rx_base = '0;         end
            default: begin tx_cap = CW'(DEPTH); rx_cap = CW'(DEPTH); rx_base = AW'(DEPTH); end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: JOIN_NONE};
        else        st_q <= st_d;
    end

    xfer_fifo_ptr #(.SLOTS(SLOTS)) u_tx_ptr (
        .clk(clk), .rst_n(rst_n), .flush(flush_all), .base('0), .cap(tx_cap),
        .push(bus_wr_en), .pop(mc_tx_ready), .push_fire(tx_push),
        .wr_addr(tx_wa), .rd_addr(tx_ra), .full(tx_full), .empty(tx_empty)
    );

    xfer_fifo_ptr #(.SLOTS(SLOTS)) u_rx_ptr (
        .clk(clk), .rst_n(rst_n), .flush(flush_all), .base(rx_base), .cap(rx_cap),
        .push(mc_rx_valid), .pop(bus_rd_en), .push_fire(rx_push),
        .wr_addr(rx_wa), .rd_addr(rx_ra), .full(rx_full), .empty(rx_empty)
    );

    xfer_fifo_mem #(.DW(DW), .SLOTS(SLOTS)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wa_en(tx_push), .wa_addr(tx_wa), .wa_data(bus_wr_data),
        .wb_en(rx_push), .wb_addr(rx_wa), .wb_data(mc_rx_data),
        .ra_addr(tx_ra), .ra_data(tx_head),
        .rb_addr(rx_ra), .rb_data(rx_head)
    );

    always_comb begin
        flag_set              = '0;
        flag_set[FLG_TXSTALL] = mc_tx_ready && tx_empty;
        flag_set[FLG_TXOVER]  = bus_wr_en && tx_full;
        flag_set[FLG_RXUNDER] = bus_rd_en && rx_empty;
        flag_set[FLG_RXSTALL] = mc_rx_valid && rx_full;
    end

    xfer_fifo_dbg #(.NF(NUM_FLAGS)) u_dbg (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(dbg_clr), .flags(dbg_flags)
    );

    assign mc_tx_valid = !tx_empty;
    assign mc_tx_data  = tx_head;
    assign mc_rx_ready = !rx_full;
    assign bus_rd_data = rx_empty ? '0 : rx_head;
    assign irq_tx      = irq_tx_en && !tx_full;
    assign irq_rx      = irq_rx_en && !rx_empty;

    // R4
    join_tx_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == JOIN_TX) |-> (rx_full && rx_empty));

    // R5
    join_rx_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == JOIN_RX) |-> (tx_full && tx_empty));

    // R6
    mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req != st_q.mode) |=> (tx_empty && rx_empty));

    // R9
    tx_over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && tx_full) |=> dbg_flags[FLG_TXOVER]);
endmodule

// File: tb/tb_xfer_fifo_pair.sv
`timescale 1ns/1ps
module tb_xfer_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  join_mode = 2'd0;
    logic        flush = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rd_data;
    logic        mc_tx_valid;
    logic        mc_tx_ready = 1'b0;
    logic [31:0] mc_tx_data;
    logic        mc_rx_valid = 1'b0;
    logic        mc_rx_ready;
    logic [31:0] mc_rx_data = '0;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic        irq_tx_en = 1'b1, irq_rx_en = 1'b1;
    logic        irq_tx, irq_rx;
    logic [3:0]  dbg_clr = '0;
    logic [3:0]  dbg_flags;

    int checks = 0;
    int bad = 0;
    logic [31:0] got;

    always #2 clk = ~clk;

    xfer_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .join_mode(join_mode), .flush(flush),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .mc_tx_valid(mc_tx_valid), .mc_tx_ready(mc_tx_ready), .mc_tx_data(mc_tx_data),
        .mc_rx_valid(mc_rx_valid), .mc_rx_ready(mc_rx_ready), .mc_rx_data(mc_rx_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .irq_tx_en(irq_tx_en), .irq_rx_en(irq_rx_en), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .dbg_clr(dbg_clr), .dbg_flags(dbg_flags)
    );

    // op: 0 bus write, 1 machine push, 2 machine pull, 3 bus read
    // row: op, data in, expected data out, expected {tx_full,tx_empty,rx_full,rx_empty}
    localparam logic [69:0] VEC [16] = '{
        {2'd0, 32'h0000_00A1, 32'h0, 4'b0001},
        {2'd0, 32'h0000_00A2, 32'h0, 4'b0001},
        {2'd0, 32'h0000_00A3, 32'h0, 4'b0001},
        {2'd0, 32'h0000_00A4, 32'h0, 4'b1001},
        {2'd2, 32'h0, 32'h0000_00A1, 4'b0001},
        {2'd1, 32'h0000_00B1, 32'h0, 4'b0000},
        {2'd1, 32'h0000_00B2, 32'h0, 4'b0000},
        {2'd1, 32'h0000_00B3, 32'h0, 4'b0000},
        {2'd1, 32'h0000_00B4, 32'h0, 4'b0010},
        {2'd3, 32'h0, 32'h0000_00B1, 4'b0000},
        {2'd2, 32'h0, 32'h0000_00A2, 4'b0000},
        {2'd2, 32'h0, 32'h0000_00A3, 4'b0000},
        {2'd2, 32'h0, 32'h0000_00A4, 4'b0100},
        {2'd3, 32'h0, 32'h0000_00B2, 4'b0100},
        {2'd3, 32'h0, 32'h0000_00B3, 4'b0100},
        {2'd3, 32'h0, 32'h0000_00B4, 4'b0101}
    };

    function automatic logic [3:0] status();
        return {tx_full, tx_empty, rx_full, rx_empty};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [31:0] d);
        @(negedge clk);
        case (op)
            2'd0: begin bus_wr_en = 1'b1; bus_wr_data = d; end
            2'd1: begin mc_rx_valid = 1'b1; mc_rx_data = d; end
            2'd2: mc_tx_ready = 1'b1;
            default: bus_rd_en = 1'b1;
        endcase
        #1;
        got = (op == 2'd2) ? mc_tx_data : bus_rd_data;
        @(posedge clk);
        #1;
        bus_wr_en = 1'b0; mc_rx_valid = 1'b0; mc_tx_ready = 1'b0; bus_rd_en = 1'b0;
    endtask

    task automatic pulse_clr(input logic [3:0] m);
        @(negedge clk);
        dbg_clr = m;
        @(posedge clk);
        #1;
        dbg_clr = '0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        join_mode = m;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        checks++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 status", 32'(status()), 32'(4'b0101));
        check("R1 flags", 32'(dbg_flags), 32'h0);
        check("R8 irq reset", 32'({irq_tx, irq_rx}), 32'(2'b10));

        // vector table: unjoined TX and RX paths (R2, R3)
        for (int i = 0; i < 16; i++) begin
            do_op(VEC[i][69:68], VEC[i][67:36]);
            if (VEC[i][69:68] >= 2'd2) check($sformatf("R2 R3 data row %0d", i), got, VEC[i][35:4]);
            check($sformatf("R2 R3 status row %0d", i), 32'(status()), 32'(VEC[i][3:0]));
        end
        check("R3 no flags after table", 32'(dbg_flags), 32'h0);

        // R9 overflow: fifth write dropped
        for (int i = 0; i < 5; i++) do_op(2'd0, 32'hC0 + 32'(i));
        check("R9 tx overflow flag", 32'(dbg_flags), 32'(4'b0010));
        for (int i = 0; i < 4; i++) begin
            do_op(2'd2, 32'h0);
            check("R9 tx order after drop", got, 32'hC0 + 32'(i));
        end
        check("R9 tx empty", 32'(tx_empty), 32'h1);
        do_op(2'd3, 32'h0);
        check("R9 underflow data zero", got, 32'h0);
        check("R9 underflow flag", 32'(dbg_flags), 32'(4'b0110));
        pulse_clr(4'b0110);
        check("R11 clear", 32'(dbg_flags), 32'h0);

        // R10 stalls
        do_op(2'd2, 32'h0);
        check("R10 tx stall", 32'(dbg_flags), 32'(4'b0001));
        for (int i = 0; i < 4; i++) do_op(2'd1, 32'hD0 + 32'(i));
        check("R3 rx ready low when full", 32'(mc_rx_ready), 32'h0);
        do_op(2'd1, 32'hDF);
        check("R10 rx stall", 32'(dbg_flags), 32'(4'b1001));

        // R11 set beats clear, other bit cleared
        @(negedge clk);
        mc_tx_ready = 1'b1;
        dbg_clr = 4'b1001;
        @(posedge clk);
        #1;
        mc_tx_ready = 1'b0;
        dbg_clr = '0;
        check("R11 set wins", 32'(dbg_flags), 32'(4'b0001));
        pulse_clr(4'b0001);
        check("R11 clear one", 32'(dbg_flags), 32'h0);

        // R8 interrupts
        @(negedge clk);
        check("R8 irq rx nonempty", 32'({irq_tx, irq_rx}), 32'(2'b11));
        for (int i = 0; i < 4; i++) do_op(2'd0, 32'hE0 + 32'(i));
        check("R8 irq tx full", 32'(irq_tx), 32'h0);
        irq_rx_en = 1'b0;
        #1;
        check("R8 irq rx disabled", 32'(irq_rx), 32'h0);
        irq_rx_en = 1'b1;

        // R7 flush
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
        check("R7 flush status", 32'(status()), 32'(4'b0101));
        do_op(2'd0, 32'h0000_0F01);
        do_op(2'd2, 32'h0);
        check("R7 fresh word after flush", got, 32'h0000_0F01);

        // R6 mode change with queued words, then R4 join TX
        do_op(2'd0, 32'h11);
        do_op(2'd0, 32'h12);
        set_mode(2'd1);
        check("R6 R4 mode change flushes", 32'(status()), 32'(4'b0111));
        for (int i = 0; i < 7; i++) do_op(2'd0, 32'h100 + 32'(i));
        check("R4 not full at 7", 32'(tx_full), 32'h0);
        do_op(2'd0, 32'h107);
        check("R4 full at 8", 32'(tx_full), 32'h1);
        check("R4 rx closed ready", 32'(mc_rx_ready), 32'h0);
        do_op(2'd1, 32'hBAD);
        check("R4 rx push stalls", 32'(dbg_flags), 32'(4'b1000));
        for (int i = 0; i < 8; i++) begin
            do_op(2'd2, 32'h0);
            check("R4 joined tx order", got, 32'h100 + 32'(i));
        end
        pulse_clr(4'b1111);

        // R5 join RX
        set_mode(2'd2);
        check("R5 join rx status", 32'(status()), 32'(4'b1101));
        for (int i = 0; i < 7; i++) do_op(2'd1, 32'h200 + 32'(i));
        check("R5 not full at 7", 32'(rx_full), 32'h0);
        do_op(2'd1, 32'h207);
        check("R5 full at 8", 32'(rx_full), 32'h1);
        do_op(2'd0, 32'hBAD);
        check("R5 tx write dropped", 32'(dbg_flags), 32'(4'b0010));
        for (int i = 0; i < 8; i++) begin
            do_op(2'd3, 32'h0);
            check("R5 joined rx order", got, 32'h200 + 32'(i));
        end
        set_mode(2'd3);
        check("R5 mode 3 unjoined", 32'(status()), 32'(4'b0101));
        for (int i = 0; i < 4; i++) do_op(2'd0, 32'h300 + 32'(i));
        check("R5 mode 3 tx depth 4", 32'(tx_full), 32'h1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule